// File: doc/BRIEF.md
# Sub-Addressed Host Control Register Interface

This block is a bus slave that a host processor uses to program a telephone-line controller. The host bus is asynchronous to the block's system clock. It has an active-low chip select, a write strobe, a read strobe, a 2-bit register address and an 8-bit data bus. The block synchronises the strobes and detects the rising edge of the write strobe while chip select is low. It then stores the bus data into one of ten control registers. Pages 00 and 11 of the address are split further: the top two data bits pick one of four registers, and the lower six bits are the payload. Pages 01 and 10 take the whole byte, and page 10 also carries a one-shot release command in bit 0. When chip select and the read strobe are both low, the block puts an 8-bit external input port on the data bus. At all other times the data bus is released.

The host must leave a minimum gap between writes. A write that arrives too soon is dropped and sets a sticky violation flag. The block watches the reference clocks to choose the gap. If every reference clock has toggled recently, and has kept doing so for a settling period, the short gap applies. Otherwise the long gap applies. All intervals are counted in system-clock cycles. The host must hold the address and data stable from chip select low until at least four system cycles after the write strobe rises.

Top module: `hrb_bus_slave`

## Requirements
- R1: A write to address 00 stores DB[5:0] into one of four registers chosen by DB[7:6]: 00 sounder, 01 key-acknowledge tone, 10 push-button tone, 11 latch/watchdog control. The other three registers keep their values.
- R2: A write to address 01 stores all of DB[7:0] into the channel-select register. A write to address 10 stores DB[7:1] into the scan-control register, and when DB[0] is 1 it makes irq_release high for exactly one cycle.
- R3: A write to address 11 stores DB[5:0] into one of four registers chosen by DB[7:6]: 00 volume/combination, 01 power-down, 10 level/gain, 11 howler frequency.
- R4: A write accepted at address 00 with DB[7:6]=11 also makes wdt_kick high for exactly one cycle. Exactly one pulse is produced for each such write.
- R5: A write strobe edge while cs_n is high changes no register, produces no pulse and does not set the violation flag.
- R6: When cs_n and rd_n are both low, db_oe is 1 and db_out equals pin. Otherwise db_oe is 0 and db_out is 0.
- R7: A write is accepted only if at least the current minimum gap, counted in system cycles, has passed since the previous accepted write. The first write after reset is always accepted. A dropped write changes no register and sets wr_violation, which stays set until reset.
- R8: The minimum gap is FAST_GAP while clk_ok is 1 and SLOW_GAP while clk_ok is 0.
- R9: clk_ok becomes 1 only after every reference clock has been alive for SETTLE_CYC cycles. A clock counts as alive when it has had a rising edge within the last REF_TIMEOUT cycles. clk_ok returns to 0 after any reference clock stops.
- R10: After reset, every control register is 0, the pulses and the violation flag are 0, db_oe is 0 and clk_ok is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, data taken on its rising edge |
| rd_n | input | 1 | Read strobe, active low |
| addr | input | 2 | Register page address |
| db_in | input | DW | Data bus from the host |
| db_out | output | DW | Data bus toward the host |
| db_oe | output | 1 | Data bus output enable |
| pin | input | DW | External input port read by the host |
| ref_clk | input | N_REF | Reference clocks being watched |
| snd_ctl | output | DW-2 | Sounder control |
| keyack_ctl | output | DW-2 | Key-acknowledge tone control |
| dtmf_ctl | output | DW-2 | Push-button tone control |
| latch_ctl | output | DW-2 | Latch control and watchdog page |
| vol_ctl | output | DW-2 | Sounder volume and tone combination |
| pwr_ctl | output | DW-2 | Codec power-down control |
| lvl_ctl | output | DW-2 | Transmit/tone level and receive gain |
| howl_ctl | output | DW-2 | Howler tone frequency |
| chan_sel | output | DW | Channel selector |
| scan_ctl | output | DW-1 | Key-scan output control |
| wdt_kick | output | 1 | One-cycle watchdog restart pulse |
| irq_release | output | 1 | One-cycle interrupt release pulse |
| wr_violation | output | 1 | Sticky flag for a dropped write |
| clk_ok | output | 1 | Reference clocks present and settled |

## Verification
The hardest conditions to reach from the ports are the two edges of the write-gap rule. A write must land exactly one cycle before the gap expires, and another exactly on it, and this must happen under both the slow and the fast gap. The bench measures in cycles when each write strobe rises, and it schedules directed writes to arrive at the last accepted write plus the gap, and at one cycle less. It switches the reference clocks on and off so that the limit changes between phases. Random writes with idle times on both sides of each limit then mix accepted and dropped writes across all pages.

// File: rtl/hrb_pkg.sv
package hrb_pkg;

  // Register page selected by the address pins
  typedef enum logic [1:0] {
    PG_BASE = 2'b00,
    PG_CHAN = 2'b01,
    PG_SCAN = 2'b10,
    PG_EXT  = 2'b11
  } reg_page_e;

  localparam int SUB_W   = 2;
  localparam int N_SUB   = 1 << SUB_W;

  // Sub-slot indices inside the base page
  localparam int SUB_SND    = 0;
  localparam int SUB_KEYACK = 1;
  localparam int SUB_DTMF   = 2;
  localparam int SUB_LATCH  = 3;

  // Sub-slot indices inside the extended page
  localparam int SUB_VOL  = 0;
  localparam int SUB_PWR  = 1;
  localparam int SUB_LVL  = 2;
  localparam int SUB_HOWL = 3;

endpackage

// File: rtl/hrb_sync.sv
module hrb_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_async;
      sync_q <= meta_q;
    end
  end

  assign q_sync = sync_q;

endmodule

// File: rtl/hrb_ref_mon.sv
module hrb_ref_mon #(
  parameter int N_REF       = 2,
  parameter int REF_TIMEOUT = 16,
  parameter int SETTLE_CYC  = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REF-1:0] ref_raw,
  output logic [N_REF-1:0] alive,
  output logic             clk_ok
);

  localparam int MW = $clog2(REF_TIMEOUT + 1);
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [MW-1:0] MISS_MAX   = MW'(REF_TIMEOUT);
  localparam logic [SW-1:0] SETTLE_MAX = SW'(SETTLE_CYC);

  logic [N_REF-1:0] ref_s;
  logic [N_REF-1:0] ref_prev_q;
  logic [N_REF-1:0] ref_rise;

  hrb_sync #(.W(N_REF), .RST_VAL('0)) u_ref_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (ref_raw),
    .q_sync  (ref_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_prev_q <= '0;
    else        ref_prev_q <= ref_s;
  end

  assign ref_rise = ref_s & ~ref_prev_q;

  // One silence counter per reference clock
  for (genvar g = 0; g < N_REF; g++) begin : g_ref
    logic [MW-1:0] miss_q;
    logic [MW-1:0] miss_d;

    always_comb begin
      if (ref_rise[g])            miss_d = '0;
      else if (miss_q < MISS_MAX) miss_d = miss_q + 1'b1;
      else                        miss_d = miss_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) miss_q <= MISS_MAX;
      else        miss_q <= miss_d;
    end

    assign alive[g] = (miss_q < MISS_MAX);
  end

  // Settling counter: runs while all clocks are alive
  logic [SW-1:0] settle_q;
  logic [SW-1:0] settle_d;

  always_comb begin
    if (!(&alive))                settle_d = '0;
    else if (settle_q < SETTLE_MAX) settle_d = settle_q + 1'b1;
    else                          settle_d = settle_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) settle_q <= '0;
    else        settle_q <= settle_d;
  end

  assign clk_ok = (settle_q == SETTLE_MAX);

endmodule

// File: rtl/hrb_pacer.sv
module hrb_pacer #(
  parameter int FAST_GAP = 40,
  parameter int SLOW_GAP = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_edge,
  input  logic fast,
  output logic wr_accept,
  output logic wr_violation,
  output logic [$clog2(SLOW_GAP + 1)-1:0] gap
);

  localparam int GW = $clog2(SLOW_GAP + 1);
  localparam logic [GW-1:0] FAST_L = GW'(FAST_GAP);
  localparam logic [GW-1:0] SLOW_L = GW'(SLOW_GAP);

  logic [GW-1:0] gap_q;
  logic [GW-1:0] gap_d;
  logic [GW-1:0] limit;
  logic          viol_q;
  logic          viol_d;
  logic          wr_drop;

  assign limit     = fast ? FAST_L : SLOW_L;
  assign wr_accept = wr_edge & (gap_q >= limit);
  assign wr_drop   = wr_edge & ~(gap_q >= limit);

  always_comb begin
    if (wr_accept)          gap_d = GW'(1);
    else if (gap_q < SLOW_L) gap_d = gap_q + 1'b1;
    else                    gap_d = gap_q;
    viol_d = viol_q | wr_drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= SLOW_L;
      viol_q <= 1'b0;
    end else begin
      gap_q  <= gap_d;
      viol_q <= viol_d;
    end
  end

  assign wr_violation = viol_q;
  assign gap          = gap_q;

endmodule

// File: rtl/hrb_bus_slave.sv
module hrb_bus_slave
  import hrb_pkg::*;
#(
  parameter int DW          = 8,
  parameter int FAST_GAP    = 40,
  parameter int SLOW_GAP    = 200,
  parameter int SETTLE_CYC  = 100,
  parameter int REF_TIMEOUT = 16,
  parameter int N_REF       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    db_in,
  output logic [DW-1:0]    db_out,
  output logic             db_oe,
  input  logic [DW-1:0]    pin,
  input  logic [N_REF-1:0] ref_clk,
  output logic [DW-3:0]    snd_ctl,
  output logic [DW-3:0]    keyack_ctl,
  output logic [DW-3:0]    dtmf_ctl,
  output logic [DW-3:0]    latch_ctl,
  output logic [DW-3:0]    vol_ctl,
  output logic [DW-3:0]    pwr_ctl,
  output logic [DW-3:0]    lvl_ctl,
  output logic [DW-3:0]    howl_ctl,
  output logic [DW-1:0]    chan_sel,
  output logic [DW-2:0]    scan_ctl,
  output logic             wdt_kick,
  output logic             irq_release,
  output logic             wr_violation,
  output logic             clk_ok
);

  localparam int PW = DW - SUB_W;
  localparam int GW = $clog2(SLOW_GAP + 1);

  // ---------------- strobe synchronisation ----------------
  logic [2:0] strobe_s;
  logic       cs_s, wr_s, rd_s;
  logic       wr_prev_q;
  logic       wr_edge;

  hrb_sync #(.W(3), .RST_VAL(3'b111)) u_strobe_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({cs_n, wr_n, rd_n}),
    .q_sync  (strobe_s)
  );

  assign cs_s = strobe_s[2];
  assign wr_s = strobe_s[1];
  assign rd_s = strobe_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_prev_q <= 1'b1;
    else        wr_prev_q <= wr_s;
  end

  assign wr_edge = wr_s & ~wr_prev_q & ~cs_s;

  // ---------------- clock presence and pacing ----------------
  logic [N_REF-1:0] ref_alive;
  logic             wr_accept;
  logic [GW-1:0]    gap;

  hrb_ref_mon #(
    .N_REF       (N_REF),
    .REF_TIMEOUT (REF_TIMEOUT),
    .SETTLE_CYC  (SETTLE_CYC)
  ) u_ref_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_raw (ref_clk),
    .alive   (ref_alive),
    .clk_ok  (clk_ok)
  );

  hrb_pacer #(
    .FAST_GAP (FAST_GAP),
    .SLOW_GAP (SLOW_GAP)
  ) u_pacer (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_edge      (wr_edge),
    .fast         (clk_ok),
    .wr_accept    (wr_accept),
    .wr_violation (wr_violation),
    .gap          (gap)
  );

  // ---------------- write decode ----------------
  reg_page_e          page;
  logic [SUB_W-1:0]   sub;
  logic [PW-1:0]      payload;
  logic [N_SUB-1:0]   base_we;
  logic [N_SUB-1:0]   ext_we;
  logic               chan_we;
  logic               scan_we;

  assign page    = reg_page_e'(addr);
  assign sub     = db_in[DW-1 -: SUB_W];
  assign payload = db_in[PW-1:0];

  always_comb begin
    base_we = '0;
    ext_we  = '0;
    chan_we = 1'b0;
    scan_we = 1'b0;
    if (wr_accept) begin
      unique case (page)
        PG_BASE: base_we = N_SUB'(1) << sub;
        PG_CHAN: chan_we = 1'b1;
        PG_SCAN: scan_we = 1'b1;
        PG_EXT:  ext_we  = N_SUB'(1) << sub;
        default: ;
      endcase
    end
  end

  // ---------------- sub-addressed register banks ----------------
  logic [PW-1:0] base_q [N_SUB];
  logic [PW-1:0] ext_q  [N_SUB];

  for (genvar g = 0; g < N_SUB; g++) begin : g_sub
    logic [PW-1:0] base_d;
    logic [PW-1:0] ext_d;

    always_comb begin
      base_d = base_we[g] ? payload : base_q[g];
      ext_d  = ext_we[g]  ? payload : ext_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g] <= '0;
        ext_q[g]  <= '0;
      end else begin
        base_q[g] <= base_d;
        ext_q[g]  <= ext_d;
      end
    end
  end

  // ---------------- whole-byte registers and pulses ----------------
  logic [DW-1:0] chan_q, chan_d;
  logic [DW-2:0] scan_q, scan_d;
  logic          kick_q, kick_d;
  logic          rel_q,  rel_d;

  always_comb begin
    chan_d = chan_we ? db_in : chan_q;
    scan_d = scan_we ? db_in[DW-1:1] : scan_q;
    kick_d = base_we[SUB_LATCH];
    rel_d  = scan_we & db_in[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      scan_q <= '0;
      kick_q <= 1'b0;
      rel_q  <= 1'b0;
    end else begin
      chan_q <= chan_d;
      scan_q <= scan_d;
      kick_q <= kick_d;
      rel_q  <= rel_d;
    end
  end

  // ---------------- outputs ----------------
  assign snd_ctl     = base_q[SUB_SND];
  assign keyack_ctl  = base_q[SUB_KEYACK];
  assign dtmf_ctl    = base_q[SUB_DTMF];
  assign latch_ctl   = base_q[SUB_LATCH];
  assign vol_ctl     = ext_q[SUB_VOL];
  assign pwr_ctl     = ext_q[SUB_PWR];
  assign lvl_ctl     = ext_q[SUB_LVL];
  assign howl_ctl    = ext_q[SUB_HOWL];
  assign chan_sel    = chan_q;
  assign scan_ctl    = scan_q;
  assign wdt_kick    = kick_q;
  assign irq_release = rel_q;

  // ---------------- read path ----------------
  assign db_oe  = ~cs_s & ~rd_s;
  assign db_out = db_oe ? pin : '0;

endmodule

// File: rtl/hrb_bus_slave_chk.sv
module hrb_bus_slave_chk #(
  parameter int DW       = 8,
  parameter int SLOW_GAP = 200,
  parameter int N_REF    = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wdt_kick,
  input logic                          irq_release,
  input logic                          wr_violation,
  input logic                          wr_accept,
  input logic                          clk_ok,
  input logic [N_REF-1:0]              ref_alive,
  input logic [$clog2(SLOW_GAP+1)-1:0] gap,
  input logic [DW-1:0]                 chan_sel
);

  AST_KICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_kick |=> !wdt_kick); // R4

  AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_release |=> !irq_release); // R2

  AST_VIOLATION_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_violation |=> wr_violation); // R7

  AST_CHAN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_accept |=> $stable(chan_sel)); // R5

  AST_SLOW_GAP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_accept && !clk_ok) |-> (gap >= ($clog2(SLOW_GAP+1))'(SLOW_GAP))); // R8

  AST_OK_NEEDS_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ok |-> $past(&ref_alive)); // R9

endmodule

bind hrb_bus_slave hrb_bus_slave_chk #(
  .DW       (DW),
  .SLOW_GAP (SLOW_GAP),
  .N_REF    (N_REF)
) u_hrb_bus_slave_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wdt_kick     (wdt_kick),
  .irq_release  (irq_release),
  .wr_violation (wr_violation),
  .wr_accept    (wr_accept),
  .clk_ok       (clk_ok),
  .ref_alive    (ref_alive),
  .gap          (gap),
  .chan_sel     (chan_sel)
);

// File: tb/test_hrb_bus_slave.sv
`timescale 1ns/100ps
module test_hrb_bus_slave;

  localparam int FAST = 40;
  localparam int SLOW = 200;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, wr_n, rd_n;
  logic [1:0] addr;
  logic [7:0] db_in, db_out, pin;
  logic       db_oe;
  logic [1:0] ref_clk;
  logic [5:0] snd_ctl, keyack_ctl, dtmf_ctl, latch_ctl;
  logic [5:0] vol_ctl, pwr_ctl, lvl_ctl, howl_ctl;
  logic [7:0] chan_sel;
  logic [6:0] scan_ctl;
  logic       wdt_kick, irq_release, wr_violation, clk_ok;

  hrb_bus_slave #(
    .DW(8), .FAST_GAP(FAST), .SLOW_GAP(SLOW),
    .SETTLE_CYC(100), .REF_TIMEOUT(16), .N_REF(2)
  ) i_hrb_bus_slave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .pin(pin),
    .ref_clk(ref_clk), .snd_ctl(snd_ctl), .keyack_ctl(keyack_ctl),
    .dtmf_ctl(dtmf_ctl), .latch_ctl(latch_ctl), .vol_ctl(vol_ctl),
    .pwr_ctl(pwr_ctl), .lvl_ctl(lvl_ctl), .howl_ctl(howl_ctl),
    .chan_sel(chan_sel), .scan_ctl(scan_ctl), .wdt_kick(wdt_kick),
    .irq_release(irq_release), .wr_violation(wr_violation), .clk_ok(clk_ok)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // reference clock generator, one edge every 4 system cycles
  bit ref_en = 1'b0;
  always @(negedge clk) begin
    if (ref_en) begin
      if (cyc % 2 == 0) ref_clk <= ~ref_clk;
    end
  end

  // pulse counters sampled away from the active edge
  int kick_seen = 0, rel_seen = 0;
  always @(negedge clk) begin
    if (rst_n && wdt_kick)    kick_seen++;
    if (rst_n && irq_release) rel_seen++;
  end

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // bench model
  int exp_base [4];
  int exp_ext  [4];
  int exp_chan, exp_scan, exp_kick, exp_rel;
  bit exp_viol, fast;
  int last_acc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(input logic [1:0] a);
    case (a)
      2'b00:   return "R1";
      2'b11:   return "R3";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin exp_base[i] = 0; exp_ext[i] = 0; end
    exp_chan = 0; exp_scan = 0; exp_viol = 0;
    exp_kick = kick_seen; exp_rel = rel_seen;
    last_acc = -1000000;
  endtask

  task automatic model_write(input logic [1:0] a, input logic [7:0] d, input int rise);
    if (rise - last_acc >= (fast ? FAST : SLOW)) begin
      last_acc = rise;
      case (a)
        2'b00: begin exp_base[d[7:6]] = d[5:0]; if (d[7:6] == 2'b11) exp_kick++; end
        2'b01: exp_chan = d;
        2'b10: begin exp_scan = d[7:1]; if (d[0]) exp_rel++; end
        default: exp_ext[d[7:6]] = d[5:0];
      endcase
    end else begin
      exp_viol = 1'b1;
    end
  endtask

  task automatic check_all(input string req);
    chk(snd_ctl    == exp_base[0], req, snd_ctl,    exp_base[0]);
    chk(keyack_ctl == exp_base[1], req, keyack_ctl, exp_base[1]);
    chk(dtmf_ctl   == exp_base[2], req, dtmf_ctl,   exp_base[2]);
    chk(latch_ctl  == exp_base[3], req, latch_ctl,  exp_base[3]);
    chk(vol_ctl    == exp_ext[0],  req, vol_ctl,    exp_ext[0]);
    chk(pwr_ctl    == exp_ext[1],  req, pwr_ctl,    exp_ext[1]);
    chk(lvl_ctl    == exp_ext[2],  req, lvl_ctl,    exp_ext[2]);
    chk(howl_ctl   == exp_ext[3],  req, howl_ctl,   exp_ext[3]);
    chk(chan_sel   == exp_chan,    req, chan_sel,   exp_chan);
    chk(scan_ctl   == exp_scan,    req, scan_ctl,   exp_scan);
    chk(kick_seen  == exp_kick,    "R4", kick_seen, exp_kick);
    chk(rel_seen   == exp_rel,     "R2", rel_seen,  exp_rel);
    chk(wr_violation == exp_viol,  "R7", wr_violation, exp_viol);
  endtask

  // one bus write; the strobe rises 4 cycles after the call
  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d, input bit ce);
    int rise;
    @(negedge clk); addr = a; db_in = d; cs_n = !ce;
    @(negedge clk); wr_n = 1'b0;
    repeat (2) @(negedge clk);
    wr_n = 1'b1; rise = cyc;
    if (ce) model_write(a, d, rise);
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
  endtask

  task automatic bus_wr_at(input int target, input logic [1:0] a, input logic [7:0] d);
    while (cyc < target - 4) @(negedge clk);
    bus_wr(a, d, 1'b1);
    check_all(req_of(a));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic random_writes(input int n, input int max_idle);
    for (int i = 0; i < n; i++) begin
      logic [1:0] a;
      logic [7:0] d;
      a = 2'($urandom);
      d = 8'($urandom);
      repeat ($urandom_range(max_idle)) @(negedge clk);
      bus_wr(a, d, 1'b1);
      check_all(req_of(a));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    rst_n = 1'b0; cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1;
    addr = '0; db_in = '0; pin = '0; ref_clk = '0; fast = 1'b0;
    model_reset();
    repeat (4) @(negedge clk);
    // R10: state held in reset and right after release
    chk(db_oe == 1'b0, "R10", db_oe, 0);
    chk(clk_ok == 1'b0, "R10", clk_ok, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R10");

    // R1 / R3: each sub-address of both split pages
    for (int s = 0; s < 4; s++) begin
      bus_wr_at(last_acc + SLOW + 3, 2'b00, {2'(s), 6'(8'h11 * (s + 1))});
      bus_wr_at(last_acc + SLOW + 3, 2'b11, {2'(s), 6'(8'h2a + s)});
    end
    // R2: whole-byte pages, with and without release bit
    bus_wr_at(last_acc + SLOW, 2'b01, 8'hc5);
    bus_wr_at(last_acc + SLOW, 2'b10, 8'hb3);
    bus_wr_at(last_acc + SLOW, 2'b10, 8'h6e);

    // R7 / R8: slow gap boundary
    bus_wr_at(last_acc + SLOW - 1, 2'b01, 8'h3c);   // dropped
    chk(wr_violation == 1'b1, "R7", wr_violation, 1);
    bus_wr_at(last_acc + SLOW + 20, 2'b01, 8'h5a);  // accepted
    bus_wr_at(last_acc + SLOW, 2'b01, 8'ha7);       // exact limit accepted
    chk(chan_sel == 8'ha7, "R8", chan_sel, 8'ha7);

    // R5: write strobe with chip select high
    repeat (SLOW) @(negedge clk);
    bus_wr(2'b01, 8'h0f, 1'b0);
    bus_wr(2'b00, 8'hc9, 1'b0);
    check_all("R5");

    // R6: read path
    pin = 8'h96;
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
    repeat (4) @(negedge clk);
    chk(db_oe == 1'b1, "R6", db_oe, 1);
    chk(db_out == 8'h96, "R6", db_out, 8'h96);
    rd_n = 1'b1; repeat (4) @(negedge clk);
    chk(db_oe == 1'b0, "R6", db_oe, 0);
    chk(db_out == 8'h00, "R6", db_out, 0);
    cs_n = 1'b1; rd_n = 1'b0; repeat (4) @(negedge clk);
    chk(db_oe == 1'b0, "R6", db_oe, 0);
    rd_n = 1'b1;

    // random traffic under the slow gap
    random_writes(25, 260);

    // R9: reference clocks start
    do_reset();
    ref_en = 1'b1;
    repeat (50) @(negedge clk);
    chk(clk_ok == 1'b0, "R9", clk_ok, 0);
    repeat (110) @(negedge clk);
    chk(clk_ok == 1'b1, "R9", clk_ok, 1);
    fast = 1'b1;

    // R8: fast gap boundary
    bus_wr(2'b01, 8'h21, 1'b1);
    check_all("R8");
    bus_wr_at(last_acc + FAST, 2'b01, 8'h42);       // exact limit accepted
    chk(chan_sel == 8'h42, "R8", chan_sel, 8'h42);
    bus_wr_at(last_acc + FAST - 1, 2'b11, 8'h7f);   // dropped
    random_writes(30, 70);

    // R9: reference clocks stop
    ref_en = 1'b0;
    repeat (40) @(negedge clk);
    chk(clk_ok == 1'b0, "R9", clk_ok, 0);
    fast = 1'b0;
    random_writes(10, 260);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule